// File: doc/BRIEF.md
# DMA Bus Ownership Arbiter

This block decides, one bus cycle at a time, who owns the system bus. There are four possible owners: two DMA channels, the internal processor and an external device that asks for the bus through a hold request. The processor owns the bus by default. A pending DMA request takes the bus from the processor, unless the processor is partway through a locked memory sequence or between the two halves of a word access to an odd address. An external hold request outranks every DMA cycle. A non-maskable interrupt stops all DMA grants so that the processor can respond quickly. DMA then stays stopped until software clears a halt flag.

The arbiter only switches owners at a cycle boundary, which the bus controller marks with `cycle_done`. The ownership decision is registered on that edge. A cycle that is already running is never preempted. A two-bit mode sets how the channels share the bus: channel 0 always wins, channel 1 always wins, or the two take turns when both are requesting. For turn-taking, the arbiter keeps a record of which channel was served last.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After synchronous reset, `grant` is 4'b0100 (processor), `dma_halted` is 0, and the alternation record says channel 1 was served last, so the first contested alternating decision goes to channel 0.
- R2: `grant` is always one-hot. Bit 0 is channel 0, bit 1 is channel 1, bit 2 is the processor and bit 3 is the hold acknowledge. It takes a new value only on a clock edge where `cycle_done` is 1, and the new value is visible from that edge onward. Without `cycle_done` it holds.
- R3: At a boundary where `hold_req` is 1, the bus goes to hold (4'b1000), whatever the DMA, NMI or processor inputs are.
- R4: At a boundary with no hold, no lock, no split access and no halt, one requesting channel gets the bus over the processor.
- R5: While `cpu_locked` is 1 at a boundary, and there is no hold, the processor keeps the bus even with DMA requests pending.
- R6: While `cpu_split_odd` is 1 at a boundary, and there is no hold, the processor keeps the bus even with DMA requests pending.
- R7: When both channels request, `prio_mode` 2'b00 grants channel 0 and 2'b01 grants channel 1.
- R8: When both channels request and `prio_mode` is 2'b10 or 2'b11, the channel not served last wins. The last-served record updates, in every mode, only at a boundary that grants a DMA channel.
- R9: `nmi` high sets `dma_halted` on the next edge. At any boundary where `nmi` or `dma_halted` is 1, no channel is granted. The halt persists after `nmi` falls.
- R10: `halt_clear` clears `dma_halted` on the next edge when `nmi` is 0. When both are 1, the halt stays set.
- R11: At a boundary with no hold and no DMA request, the processor gets the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req0 | input | 1 | DMA channel 0 request |
| req1 | input | 1 | DMA channel 1 request |
| prio_mode | input | 2 | Channel priority: 00 ch0 first, 01 ch1 first, 1x alternate |
| cpu_locked | input | 1 | Processor is inside a locked sequence |
| cpu_split_odd | input | 1 | Processor is between halves of an odd-address word access |
| hold_req | input | 1 | External bus hold request |
| nmi | input | 1 | Non-maskable interrupt request |
| halt_clear | input | 1 | Software write that clears the DMA halt flag |
| cycle_done | input | 1 | Current bus cycle ends at this edge |
| grant | output | 4 | One-hot owner: bit0 ch0, bit1 ch1, bit2 processor, bit3 hold |
| dma_halted | output | 1 | DMA halted after NMI |

## Verification
Some properties are checked by the assertions on every cycle:
- `grant` is one-hot and only changes at a boundary.
- Hold wins at a boundary.
- Lock, split access, NMI or a set halt flag each keep the channels off the bus.
- An eligible request displaces the processor.
- NMI sets the halt flag.

Other behaviour depends on history, and only the bench's scenarios can show it: the alternation order across many contested cycles, the last-served record staying unchanged through boundaries that grant hold or the processor, the halt persisting after NMI falls, and NMI winning over a simultaneous clear. The bench follows a model of the requirements through directed sequences and a long seeded random run.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int GNT_W  = 4;
  localparam int G_CH0  = 0;
  localparam int G_CH1  = 1;
  localparam int G_CPU  = 2;
  localparam int G_HOLD = 3;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    PM_CH0_FIRST = 2'b00,
    PM_CH1_FIRST = 2'b01,
    PM_ALT_A     = 2'b10,
    PM_ALT_B     = 2'b11
  } prio_mode_e;

  function automatic logic [GNT_W-1:0] owner_bit(input int idx);
    logic [GNT_W-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/dma_arb_halt.sv
module dma_arb_halt (
  input  logic clk,
  input  logic rst,
  input  logic nmi,
  input  logic halt_clear,
  output logic halted,
  output logic dma_block
);
  always_ff @(posedge clk) begin
    if (rst)             halted <= 1'b0;
    else if (nmi)        halted <= 1'b1;
    else if (halt_clear) halted <= 1'b0;
  end

  // NMI blocks DMA in the very cycle it is raised, not only once latched
  assign dma_block = halted | nmi;
endmodule

// File: rtl/dma_arb_chsel.sv
module dma_arb_chsel
  import dma_arb_pkg::*;
(
  input  logic              req0,
  input  logic              req1,
  input  logic [MODE_W-1:0] mode,
  input  logic              last_ch1,
  output logic              pick_ch1
);
  always_comb begin
    if (req0 && !req1)      pick_ch1 = 1'b0;
    else if (!req0 && req1) pick_ch1 = 1'b1;
    else begin
      case (prio_mode_e'(mode))
        PM_CH0_FIRST: pick_ch1 = 1'b0;
        PM_CH1_FIRST: pick_ch1 = 1'b1;
        default:      pick_ch1 = ~last_ch1;
      endcase
    end
  end
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter bit ALT_FIRST_CH1 = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req0,
  input  logic              req1,
  input  logic [MODE_W-1:0] prio_mode,
  input  logic              cpu_locked,
  input  logic              cpu_split_odd,
  input  logic              hold_req,
  input  logic              nmi,
  input  logic              halt_clear,
  input  logic              cycle_done,
  output logic [GNT_W-1:0]  grant,
  output logic              dma_halted
);
  // the record starts as if the other channel was served last
  localparam logic LAST_RESET = ~ALT_FIRST_CH1;

  logic             last_ch1;
  logic             pick_ch1;
  logic             dma_block;
  logic             dma_ok;
  logic [GNT_W-1:0] next_gnt;

  dma_arb_halt u_halt (
    .clk        (clk),
    .rst        (rst),
    .nmi        (nmi),
    .halt_clear (halt_clear),
    .halted     (dma_halted),
    .dma_block  (dma_block)
  );

  dma_arb_chsel u_chsel (
    .req0     (req0),
    .req1     (req1),
    .mode     (prio_mode),
    .last_ch1 (last_ch1),
    .pick_ch1 (pick_ch1)
  );

  assign dma_ok = (req0 | req1) & ~dma_block & ~cpu_locked & ~cpu_split_odd;

  always_comb begin
    if (hold_req)    next_gnt = owner_bit(G_HOLD);
    else if (dma_ok) next_gnt = pick_ch1 ? owner_bit(G_CH1) : owner_bit(G_CH0);
    else             next_gnt = owner_bit(G_CPU);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant    <= owner_bit(G_CPU);
      last_ch1 <= LAST_RESET;
    end else if (cycle_done) begin
      grant <= next_gnt;
      if (!hold_req && dma_ok) last_ch1 <= pick_ch1;
    end
  end
endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk (
  input logic       clk,
  input logic       rst,
  input logic       req0,
  input logic       req1,
  input logic       cpu_locked,
  input logic       cpu_split_odd,
  input logic       hold_req,
  input logic       nmi,
  input logic       cycle_done,
  input logic [3:0] grant,
  input logic       dma_halted
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(grant) == 1);

  p_hold_only_at_boundary_r2: assert property (@(posedge clk) disable iff (rst)
    !cycle_done |=> $stable(grant));

  p_hold_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (cycle_done && hold_req) |=> grant == 4'b1000);

  p_dma_over_cpu_r4: assert property (@(posedge clk) disable iff (rst)
    (cycle_done && !hold_req && !cpu_locked && !cpu_split_odd && !nmi &&
     !dma_halted && (req0 || req1)) |=> (grant[0] || grant[1]));

  p_lock_keeps_cpu_r5: assert property (@(posedge clk) disable iff (rst)
    (cycle_done && !hold_req && cpu_locked) |=> grant == 4'b0100);

  p_split_keeps_cpu_r6: assert property (@(posedge clk) disable iff (rst)
    (cycle_done && !hold_req && cpu_split_odd) |=> grant == 4'b0100);

  p_nmi_sets_halt_r9: assert property (@(posedge clk) disable iff (rst)
    nmi |=> dma_halted);

  p_halt_blocks_dma_r9: assert property (@(posedge clk) disable iff (rst)
    (cycle_done && (nmi || dma_halted)) |=> !(grant[0] || grant[1]));

  p_idle_cpu_r11: assert property (@(posedge clk) disable iff (rst)
    (cycle_done && !hold_req && !req0 && !req1) |=> grant == 4'b0100);
endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk i_chk (
  .clk           (clk),
  .rst           (rst),
  .req0          (req0),
  .req1          (req1),
  .cpu_locked    (cpu_locked),
  .cpu_split_odd (cpu_split_odd),
  .hold_req      (hold_req),
  .nmi           (nmi),
  .cycle_done    (cycle_done),
  .grant         (grant),
  .dma_halted    (dma_halted)
);

// File: tb/test_dma_bus_arbiter.sv
`timescale 1ns/1ps
module test_dma_bus_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req0 = 0, req1 = 0, cpu_locked = 0, cpu_split_odd = 0;
  logic       hold_req = 0, nmi = 0, halt_clear = 0, cycle_done = 0;
  logic [1:0] prio_mode = 2'b00;
  logic [3:0] grant;
  logic       dma_halted;

  int n_chk = 0;
  int n_err = 0;

  // bench model state
  logic [3:0] m_gnt;
  logic       m_halt;
  logic       m_last1;

  always #4 clk = ~clk;

  dma_bus_arbiter i_dma_bus_arbiter (
    .clk(clk), .rst(rst), .req0(req0), .req1(req1), .prio_mode(prio_mode),
    .cpu_locked(cpu_locked), .cpu_split_odd(cpu_split_odd), .hold_req(hold_req),
    .nmi(nmi), .halt_clear(halt_clear), .cycle_done(cycle_done),
    .grant(grant), .dma_halted(dma_halted)
  );

  function automatic bit model_pick1(bit r0, bit r1, logic [1:0] md, bit last1);
    if (r0 && !r1) return 1'b0;
    if (!r0 && r1) return 1'b1;
    if (md == 2'b00) return 1'b0;
    if (md == 2'b01) return 1'b1;
    return !last1;
  endfunction

  function automatic logic [3:0] model_grant(bit r0, bit r1, logic [1:0] md, bit lk,
                                            bit sp, bit hd, bit nm, bit halt, bit last1);
    if (hd) return 4'b1000;
    if ((r0 || r1) && !lk && !sp && !nm && !halt)
      return model_pick1(r0, r1, md, last1) ? 4'b0010 : 4'b0001;
    return 4'b0100;
  endfunction

  function automatic string model_tag(bit r0, bit r1, logic [1:0] md, bit lk,
                                      bit sp, bit hd, bit nm, bit halt, bit cd);
    if (!cd) return "R2";
    if (hd) return "R3";
    if (!r0 && !r1) return "R11";
    if (nm || halt) return "R9";
    if (lk) return "R5";
    if (sp) return "R6";
    if (r0 && r1) return (md[1] ? "R8" : "R7");
    return "R4";
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a negedge; drives, waits one edge, compares at next negedge
  task automatic step(bit r0, bit r1, logic [1:0] md, bit lk, bit sp,
                      bit hd, bit nm, bit cl, bit cd);
    logic [3:0] eg;
    logic       eh;
    bit         granted_dma;
    string      tg;
    req0 = r0; req1 = r1; prio_mode = md; cpu_locked = lk; cpu_split_odd = sp;
    hold_req = hd; nmi = nm; halt_clear = cl; cycle_done = cd;
    eg = cd ? model_grant(r0, r1, md, lk, sp, hd, nm, m_halt, m_last1) : m_gnt;
    tg = model_tag(r0, r1, md, lk, sp, hd, nm, m_halt, cd);
    granted_dma = cd && (eg[0] || eg[1]);
    eh = nm ? 1'b1 : (cl ? 1'b0 : m_halt);
    @(negedge clk);
    chk(tg, grant, eg);
    chk(nm ? "R9" : (cl ? "R10" : "R9"), {3'b000, dma_halted}, {3'b000, eh});
    m_gnt = eg;
    m_halt = eh;
    if (granted_dma) m_last1 = eg[1];
  endtask

  initial begin : watchdog
    #1600000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 32'h1d5a;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", grant, 4'b0100);
    chk("R1", {3'b000, dma_halted}, 4'b0000);
    m_gnt = 4'b0100; m_halt = 1'b0; m_last1 = 1'b1;

    // R1/R8 first contested alternating decision goes to ch0, then alternate
    step(1, 1, 2'b10, 0, 0, 0, 0, 0, 1);
    chk("R1", grant, 4'b0001);
    step(1, 1, 2'b11, 0, 0, 0, 0, 0, 1);
    step(1, 1, 2'b10, 0, 0, 0, 0, 0, 1);
    // R8 hold and cpu grants must not move the record
    step(1, 1, 2'b10, 0, 0, 1, 0, 0, 1);
    step(1, 1, 2'b10, 1, 0, 0, 0, 0, 1);
    step(1, 1, 2'b10, 0, 0, 0, 0, 0, 1);
    chk("R8", grant, 4'b0010);
    // R7 fixed priorities
    step(1, 1, 2'b00, 0, 0, 0, 0, 0, 1);
    step(1, 1, 2'b01, 0, 0, 0, 0, 0, 1);
    // R2 no boundary, inputs change but grant holds
    step(1, 0, 2'b00, 0, 0, 1, 0, 0, 0);
    // R6 split access, R5 locked
    step(1, 0, 2'b00, 0, 1, 0, 0, 0, 1);
    step(0, 1, 2'b00, 1, 0, 0, 0, 0, 1);
    // R4 single requester
    step(0, 1, 2'b00, 0, 0, 0, 0, 0, 1);
    // R3 hold beats nmi and requests
    step(1, 1, 2'b00, 0, 0, 1, 1, 0, 1);
    // R9 halt persists after nmi falls
    step(1, 1, 2'b00, 0, 0, 0, 0, 0, 1);
    step(1, 0, 2'b00, 0, 0, 0, 0, 0, 1);
    // R10 nmi wins over a simultaneous clear
    step(1, 0, 2'b00, 0, 0, 0, 1, 1, 1);
    chk("R10", {3'b000, dma_halted}, 4'b0001);
    // R10 clear alone then DMA resumes
    step(1, 0, 2'b00, 0, 0, 0, 0, 1, 0);
    step(1, 0, 2'b00, 0, 0, 0, 0, 0, 1);
    chk("R10", grant, 4'b0001);
    // R11 idle
    step(0, 0, 2'b10, 0, 0, 0, 0, 0, 1);

    // seeded random mix
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 100) < 55, ($urandom % 100) < 55, 2'($urandom % 4),
           ($urandom % 100) < 12, ($urandom % 100) < 10, ($urandom % 100) < 10,
           ($urandom % 100) < 3, ($urandom % 100) < 25, ($urandom % 100) < 65);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule